// File: doc/BRIEF.md
# TDM Daisy-Chain Slot Controller

This block decides when one device in a chain of identical devices may use a shared time-division multiplexed serial bus. Ownership is passed down the chain as a token, not assigned by a fixed slot number. When a slave device sees the upstream token, it takes a burst of consecutive slots. On the last bit of that burst it hands a one-clock token to the next device. A device in bus-master mode ignores the token and always takes the first slots after frame sync.

A device that is deselected or powered down drops out of the chain. It routes the upstream token combinationally to its downstream output, so the chain skips it. Outside its own slots the device releases the shared data line and produces no slot strobe. A frame sync pulse restarts slot counting and cancels any claim still in progress.

The controller has three named states. OFF is the bypassed state. IDLE waits for a token or a frame sync. CLAIM owns the bus. Its transitions are:
- any state to OFF when the device is bypassed;
- OFF to IDLE on the first edge with no bypass;
- IDLE to CLAIM on a token in slave mode, or on frame sync in master mode;
- CLAIM to IDLE on the final bit, or on frame sync in slave mode;
- CLAIM to CLAIM on frame sync in master mode, which restarts the claim at slot 0.

Top module: `tdm_slot_ctrl`

## Requirements
- R1: During reset and on the first edge after reset, `slot_act_o`, `sdo_oe_o`, `tok_o` and `slot_idx_o` are all 0.
- R2: In slave mode, while idle, selected and powered up, `tok_i` high at a rising clock edge with `fsync_i` low starts a claim. `slot_act_o` is high for exactly SLOTS*SLOT_BITS (6*16 = 96) cycles, beginning in the cycle after that edge.
- R3: In the k-th active cycle of a claim (k from 0 to 95), `slot_idx_o` equals k/16, rounded down, so it runs 0 to 5. Outside a claim it is 0.
- R4: When the device is not bypassed, `tok_o` is high for exactly one cycle: the last cycle of a claim (slot 5, bit 15). At all other times it is low.
- R5: `tok_i` has no effect during a claim, including at the edge that ends the claim.
- R6: `sdo_oe_o` equals `slot_act_o` at all times. Both fall in the same cycle that `csel_i` falls or `pwrdn_i` rises.
- R7: While `csel_i` is low, `tok_o` follows `tok_i` combinationally and no claim can start. After `csel_i` returns high, the first edge only re-arms the device; a token at that edge is ignored.
- R8: While `pwrdn_i` is high, `tok_o` follows `tok_i` combinationally, any claim in progress is dropped, and no claim can start.
- R9: In master mode, `fsync_i` high at an edge starts a claim at slot 0 in the next cycle, and `tok_i` is ignored. `clkfs_oe_o` is high exactly when `csel_i` and `master_i` are both high.
- R10: `fsync_i` high at an edge during a claim ends the claim in slave mode, and restarts it at slot 0 in master mode.
- R11: In slave mode, when `fsync_i` and `tok_i` are both high at the same edge, the frame sync wins and no claim starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync, sampled on the rising edge |
| csel_i | input | 1 | Chip select, active high |
| pwrdn_i | input | 1 | Power-down, active high |
| master_i | input | 1 | 1 selects bus-master mode, 0 selects slave mode |
| tok_i | input | 1 | Upstream slot token |
| tok_o | output | 1 | Downstream slot token |
| slot_act_o | output | 1 | High while the device owns the current bit |
| slot_idx_o | output | IDX_W (3) | Slot index within the claim |
| sdo_oe_o | output | 1 | Output enable for the shared data line |
| clkfs_oe_o | output | 1 | Output enable for the clock and frame sync drivers |

## Verification
The bench keeps the default parameters: 16-bit slots and six owned slots. Every full claim therefore runs 96 cycles, crosses all five slot boundaries and ends with the token pulse on the 96th cycle. Keeping the full widths lets the bench reach several corner cases:
- a token landing mid-claim, and a token landing on the edge that ends a claim;
- frame syncs that cut a claim short, in both slave and master mode;
- the one-edge re-arm after chip select or power-down is released.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_CLAIM = 2'd2
    } slot_state_e;
endpackage

// File: rtl/tdm_wrap_cnt.sv
module tdm_wrap_cnt #(
    parameter int LIMIT = 16,
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] q_o,
    output logic         max_o
);
    assign max_o = (q_o == W'(LIMIT - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            q_o <= '0;
        else if (clr_i)
            q_o <= '0;
        else if (inc_i)
            q_o <= max_o ? '0 : q_o + 1'b1;
    end
endmodule

// File: rtl/tdm_slot_fsm.sv
module tdm_slot_fsm
    import tdm_slot_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bypass_i,
    input  logic        master_i,
    input  logic        fsync_i,
    input  logic        tok_i,
    input  logic        done_i,
    output slot_state_e state_o,
    output logic        cnt_clr_o,
    output logic        claim_o
);
    slot_state_e state_q, state_d;
    logic        start;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        if (bypass_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_IDLE;
                ST_IDLE: begin
                    if (fsync_i) begin
                        if (master_i) begin
                            state_d = ST_CLAIM;
                            start   = 1'b1;
                        end
                    end else if (!master_i && tok_i) begin
                        state_d = ST_CLAIM;
                        start   = 1'b1;
                    end
                end
                ST_CLAIM: begin
                    if (fsync_i) begin
                        if (master_i) begin
                            state_d = ST_CLAIM;
                            start   = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else if (done_i) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        state_o   = state_q;
        cnt_clr_o = start || (state_d != ST_CLAIM);
        claim_o   = (state_q == ST_CLAIM) && !bypass_i;
    end
endmodule

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
    import tdm_slot_pkg::*;
#(
    parameter int SLOT_BITS = 16,
    parameter int SLOTS     = 6,
    localparam int IDX_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int BIT_W    = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fsync_i,
    input  logic             csel_i,
    input  logic             pwrdn_i,
    input  logic             master_i,
    input  logic             tok_i,
    output logic             tok_o,
    output logic             slot_act_o,
    output logic [IDX_W-1:0] slot_idx_o,
    output logic             sdo_oe_o,
    output logic             clkfs_oe_o
);
    slot_state_e      state_q;
    logic             bypass;
    logic             cnt_clr;
    logic             claim;
    logic             bit_max, slot_max, done;
    logic [BIT_W-1:0] bit_q;
    logic [IDX_W-1:0] slot_q;

    assign bypass = !csel_i || pwrdn_i;
    assign done   = bit_max && slot_max;

    tdm_slot_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .bypass_i (bypass),
        .master_i (master_i),
        .fsync_i  (fsync_i),
        .tok_i    (tok_i),
        .done_i   (done),
        .state_o  (state_q),
        .cnt_clr_o(cnt_clr),
        .claim_o  (claim)
    );

    // Bit position within the current slot
    tdm_wrap_cnt #(.LIMIT(SLOT_BITS)) u_bit_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (cnt_clr),
        .inc_i (1'b1),
        .q_o   (bit_q),
        .max_o (bit_max)
    );

    // Slot number within the claim
    tdm_wrap_cnt #(.LIMIT(SLOTS)) u_slot_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (cnt_clr),
        .inc_i (bit_max),
        .q_o   (slot_q),
        .max_o (slot_max)
    );

    always_comb begin
        slot_act_o = claim;
        sdo_oe_o   = claim;
        slot_idx_o = claim ? slot_q : '0;
        clkfs_oe_o = csel_i && master_i;
        tok_o      = bypass ? tok_i : (claim && done);
    end
endmodule

// File: rtl/tdm_slot_ctrl_chk.sv
module tdm_slot_ctrl_chk
    import tdm_slot_pkg::*;
#(
    parameter int SLOTS = 6,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             fsync_i,
    input logic             csel_i,
    input logic             pwrdn_i,
    input logic             master_i,
    input logic             tok_i,
    input logic             tok_o,
    input logic             slot_act_o,
    input logic [IDX_W-1:0] slot_idx_o,
    input logic             sdo_oe_o,
    input slot_state_e      state_q
);
    logic byp;
    assign byp = !csel_i || pwrdn_i;

    AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byp |-> (tok_o == tok_i)); // R7
    AST_OE_FOLLOWS_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sdo_oe_o == slot_act_o); // R6
    AST_TOK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tok_o && !byp) |=> (!tok_o || !csel_i || pwrdn_i)); // R4
    AST_TOK_ENDS_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tok_o && !byp && !fsync_i) |=> !slot_act_o); // R4
    AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_act_o |-> (int'(slot_idx_o) < SLOTS)); // R3
    AST_SLAVE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && !master_i && !byp && tok_i && !fsync_i)
        |=> ((slot_act_o && slot_idx_o == '0) || !csel_i || pwrdn_i)); // R2
    AST_MASTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_OFF && master_i && !byp && fsync_i)
        |=> ((slot_act_o && slot_idx_o == '0) || !csel_i || pwrdn_i)); // R9
    AST_SLAVE_FS_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!master_i && fsync_i && !byp) |=> !slot_act_o); // R10
    AST_PWRDN_NO_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwrdn_i |-> !slot_act_o); // R8
endmodule

bind tdm_slot_ctrl tdm_slot_ctrl_chk #(.SLOTS(SLOTS)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fsync_i   (fsync_i),
    .csel_i    (csel_i),
    .pwrdn_i   (pwrdn_i),
    .master_i  (master_i),
    .tok_i     (tok_i),
    .tok_o     (tok_o),
    .slot_act_o(slot_act_o),
    .slot_idx_o(slot_idx_o),
    .sdo_oe_o  (sdo_oe_o),
    .state_q   (state_q)
);

// File: tb/tdm_slot_ctrl_tb.sv
module tdm_slot_ctrl_tb;
    localparam int SB = 16;
    localparam int NS = 6;
    localparam int CLAIM_LEN = SB * NS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fsync = 1'b0, csel = 1'b0, pwrdn = 1'b0, master = 1'b0, tok_i = 1'b0;
    logic tok_o, slot_act, sdo_oe, clkfs_oe;
    logic [2:0] slot_idx;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic       chk;
        logic       act;
        logic       tok;
        logic       drv;
        logic [7:0] idx;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    tdm_slot_ctrl u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .fsync_i   (fsync),
        .csel_i    (csel),
        .pwrdn_i   (pwrdn),
        .master_i  (master),
        .tok_i     (tok_i),
        .tok_o     (tok_o),
        .slot_act_o(slot_act),
        .slot_idx_o(slot_idx),
        .sdo_oe_o  (sdo_oe),
        .clkfs_oe_o(clkfs_oe)
    );

    // Driver: apply inputs at the falling edge, push the outputs expected after the next rising edge
    task automatic step(input bit fs, input bit cs, input bit pd, input bit ms, input bit ti,
                        input bit e_act, input int e_idx, input bit e_tok, input string tag);
        exp_t it;
        @(negedge clk);
        fsync = fs; csel = cs; pwrdn = pd; master = ms; tok_i = ti;
        it.chk = 1'b1;
        it.act = e_act;
        it.idx = 8'(e_idx);
        it.tok = e_tok;
        it.drv = cs && ms;
        exp_q.push_back(it);
        tag_q.push_back(tag);
    endtask

    // Remaining cycles of a claim whose first cycle has already been stepped, then one idle cycle
    task automatic claim_rest(input bit ms, input string tag);
        for (int n = 1; n < CLAIM_LEN; n++)
            step(1'b0, 1'b1, 1'b0, ms, 1'b0, 1'b1, n / SB, n == CLAIM_LEN - 1, tag);
        step(1'b0, 1'b1, 1'b0, ms, 1'b0, 1'b0, 0, 1'b0, tag);
    endtask

    // Monitor: sample shortly after each rising edge and compare with the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e.chk) begin
                    n_chk++;
                    if (slot_act !== e.act || sdo_oe !== e.act || tok_o !== e.tok ||
                        clkfs_oe !== e.drv || int'(slot_idx) != int'(e.idx)) begin
                        n_err++;
                        $display("FAIL %s: act=%0b oe=%0b idx=%0d tok=%0b drv=%0b expected act=%0b oe=%0b idx=%0d tok=%0b drv=%0b",
                                 t, slot_act, sdo_oe, slot_idx, tok_o, clkfs_oe,
                                 e.act, e.act, e.idx, e.tok, e.drv);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        csel = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs held low during reset
        n_chk++;
        if (slot_act !== 1'b0 || sdo_oe !== 1'b0 || tok_o !== 1'b0 || slot_idx !== 3'd0) begin
            n_err++;
            $display("FAIL R1 reset: act=%0b oe=%0b tok=%0b idx=%0d expected all 0",
                     slot_act, sdo_oe, tok_o, slot_idx);
        end
        rst_n = 1'b1;

        // R1: first edges after reset stay idle
        repeat (3) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R1 idle");

        // R2 R3 R4: slave claim from token
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0, "R2 start");
        claim_rest(1'b0, "R2 R3 R4 claim");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R4 after");

        // R5: tokens during a claim and at its final edge are ignored
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0, "R5 start");
        for (int n = 1; n < CLAIM_LEN; n++)
            step(1'b0, 1'b1, 1'b0, 1'b0, (n % 20) == 0, 1'b1, n / SB, n == CLAIM_LEN - 1, "R5 mid");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, "R5 end edge");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R5 no reclaim");

        // R10: frame sync cancels a slave claim
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0, "R10 start");
        for (int n = 1; n < 30; n++)
            step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, n / SB, 1'b0, "R10 run");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R10 cancel");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R10 idle");

        // R11: frame sync beats token at the same edge
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, "R11 fs+tok");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R11 idle");

        // R7: chip select low passes token through and drops a claim at once
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0, "R7 start");
        for (int n = 1; n < 10; n++)
            step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b0, "R7 run");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R7 deselect");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b1, "R7 pass high");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R7 pass low");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, "R7 rearm edge");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0, "R7 claim after rearm");
        claim_rest(1'b0, "R7 claim");

        // R6 R8: power-down bypass and abort
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 0, 1'b1, "R8 pass high");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R8 pass low");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R8 rearm");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0, "R8 start");
        for (int n = 1; n < 20; n++)
            step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, n / SB, 1'b0, "R8 run");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 0, 1'b1, "R6 R8 abort");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R8 release");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R8 idle");

        // R9: master mode ignores token, claims on frame sync
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R9 idle drv");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0, "R9 tok ignored");
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R9 still idle");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R9 fs start");
        claim_rest(1'b1, "R9 claim");

        // R10: master frame sync restarts a claim
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R10 m start");
        for (int n = 1; n < 40; n++)
            step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, n / SB, 1'b0, "R10 m run");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R10 m restart");
        claim_rest(1'b1, "R10 m claim");

        // R9: clock/frame drivers released when deselected
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R9 deselect drv");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R9 slave drv");

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule